// File: doc/BRIEF.md
# Byte-Wide Configuration Stream Serializer

This block sits between a host that hands over configuration data one byte at a time and a programmable-logic device that takes that data one bit at a time. For every accepted byte it generates its own shift clock, one pulse per bit, and presents bit 0 first and bit 7 last. The serial line changes while the shift clock is low and is steady when the clock rises. A busy output tells the host when the next byte may be written.

The host ends a stream with a finish strobe that carries the last byte and the number of valid bits in it. The block fills the unused upper bits of that byte with ones and then shifts out one extra all-ones byte by itself. The device therefore gets the clock pulses it needs to complete its startup, and the clock never stops partway through a byte. On the device side the block also watches the outgoing bits for the stream header, which is a run of ones followed by the start code 0, 0, 1, 0, and raises a sticky flag once the header has gone out. A running count of data bits is kept for comparison against the expected stream length. Padding and the trailing byte are not counted.

If the finish strobe and the byte-write strobe arrive together while the block is idle, the finish strobe wins. A strobe that arrives while busy is high is dropped and recorded in a sticky overrun flag.

Top module: `cfg_stream_serializer`

## Requirements
- R1: The reset input is synchronous and active high. After reset, and whenever busy is low, the shift clock is 0, the serial data line is 1 and busy is 0. Reset clears the header flag, the overrun flag and the bit count to 0.
- R2: Each accepted byte produces 8 shift-clock pulses. The value on the serial data line at each rising shift-clock edge is bit 0 of the byte first, then bit 1, and so on up to bit 7. The serial data line changes only in cycles where the shift clock is low.
- R3: The header flag becomes 1 at the rising shift-clock edge that carries the last bit of the sent-bit sequence 1, 0, 0, 1, 0, taken in send order. In other words it rises after at least one one-bit followed by the start code 0, 0, 1, 0. Once set, it stays at 1 until reset.
- R4: Busy goes high in the cycle after an accepted strobe. For a plain byte it stays high for exactly 16 clock cycles (two cycles per bit), and then a new byte may be accepted.
- R5: The bit count increases by one at each rising shift-clock edge that carries a data bit. It does not count pad bits or the trailing byte.
- R6: A byte-write or finish strobe that arrives while busy is high has no effect on the serial stream or the count, and it sets the overrun flag. The overrun flag stays at 1 until reset.
- R7: A finish strobe sends the lowest n bits of the byte, where n is given by the finish bit-count input, followed by 8−n one-bits. A value of 0 or a value above 8 is treated as 8.
- R8: After the last byte of a finish strobe, a byte of 8 one-bits follows with no host write. Busy stays high for all 32 cycles, during which 16 shift-clock pulses are produced.
- R9: While busy stays high, the shift clock toggles every clock cycle, so no byte, including the trailing byte, is left partly clocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Write strobe for one byte of configuration data |
| wr_data | input | 8 | Byte to send; also carries the last byte with the finish strobe |
| fin_stb | input | 1 | Finish strobe: the last byte, then padding and the trailing byte |
| fin_nbits | input | 4 | Number of valid bits in the last byte (1 to 8) |
| busy | output | 1 | High while a byte or the finish sequence is being shifted |
| sclk | output | 1 | Shift clock to the device |
| sdata | output | 1 | Serial configuration data to the device |
| hdr_seen | output | 1 | Sticky flag: the header has been sent |
| overrun | output | 1 | Sticky flag: a strobe arrived while busy |
| bit_count | output | CNT_W | Number of data bits sent since reset |

## Verification
A bit index that is one off shows at the ports at the very next shift-clock rise, as a serial bit that does not match the expected least-significant-first order. It also shows as a busy interval of the wrong length. If the block loses the trailer pending state, busy falls after 16 cycles instead of 32 and eight pulses are missing. If the header detector is in the wrong state, the flag is wrong at the rising edge of the final start-code bit. The count register is compared against the expected data length after each byte. Any growth from pad bits or a dropped strobe shows within one byte time.

// File: rtl/cfg_ser_pkg.sv
package cfg_ser_pkg;
  localparam int BYTE_W = 8;
  localparam int NB_W   = $clog2(BYTE_W + 1);
  localparam int IDX_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {H_WAIT, H_RUN, H_Z1, H_Z2, H_ONE, H_HIT} hdr_st_t;

  // Valid-bit count of the last byte; out-of-range values mean a full byte.
  function automatic logic [NB_W-1:0] eff_nbits(input logic [NB_W-1:0] n);
    return (n == '0 || n > NB_W'(BYTE_W)) ? NB_W'(BYTE_W) : n;
  endfunction

  // Force every bit at position n and above to one.
  function automatic logic [BYTE_W-1:0] pad_ones(input logic [BYTE_W-1:0] d,
                                                 input logic [NB_W-1:0] n);
    logic [2*BYTE_W-1:0] m;
    m = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}} << n;
    return d | m[BYTE_W-1:0];
  endfunction

  // Header tracker: at least one 1, then 0,0,1,0.
  function automatic hdr_st_t hdr_next(input hdr_st_t s, input logic b);
    case (s)
      H_WAIT:  return b ? H_RUN : H_WAIT;
      H_RUN:   return b ? H_RUN : H_Z1;
      H_Z1:    return b ? H_RUN : H_Z2;
      H_Z2:    return b ? H_ONE : H_WAIT;
      H_ONE:   return b ? H_RUN : H_HIT;
      default: return H_HIT;
    endcase
  endfunction
endpackage

// File: rtl/cfg_hdr_detect.sv
module cfg_hdr_detect
  import cfg_ser_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_fire,
  input  logic bit_val,
  output logic seen
);
  hdr_st_t st_q;

  always_ff @(posedge clk) begin
    if (rst)           st_q <= H_WAIT;
    else if (bit_fire) st_q <= hdr_next(st_q, bit_val);
  end

  assign seen = (st_q == H_HIT);
endmodule

// File: rtl/cfg_bit_counter.sv
module cfg_bit_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/cfg_shift_core.sv
module cfg_shift_core
  import cfg_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              fin_stb,
  input  logic [NB_W-1:0]   fin_nbits,
  output logic              busy,
  output logic              sclk,
  output logic              sdata,
  output logic              overrun,
  output logic              bit_fire,
  output logic              bit_val,
  output logic              bit_is_data
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  logic              active_q, phase_q, trail_q, sclk_q, ovr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] sreg_q;
  logic [NB_W-1:0]   nvalid_q;

  logic              load_go, load_trail;
  logic [BYTE_W-1:0] load_byte;
  logic [NB_W-1:0]   load_n;

  always_comb begin
    load_go    = !active_q && (wr_stb || fin_stb);
    load_trail = fin_stb;
    load_n     = fin_stb ? eff_nbits(fin_nbits) : NB_W'(BYTE_W);
    load_byte  = fin_stb ? pad_ones(wr_data, load_n) : wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      trail_q  <= 1'b0;
      sclk_q   <= 1'b0;
      ovr_q    <= 1'b0;
      idx_q    <= '0;
      sreg_q   <= '1;
      nvalid_q <= '0;
    end else begin
      if (active_q && (wr_stb || fin_stb)) ovr_q <= 1'b1;
      if (!active_q) begin
        if (load_go) begin
          active_q <= 1'b1;
          phase_q  <= 1'b0;
          idx_q    <= '0;
          sreg_q   <= load_byte;
          nvalid_q <= load_n;
          trail_q  <= load_trail;
        end
      end else if (!phase_q) begin
        sclk_q  <= 1'b1;
        phase_q <= 1'b1;
      end else begin
        sclk_q  <= 1'b0;
        phase_q <= 1'b0;
        if (idx_q == LAST_IDX) begin
          sreg_q <= '1;
          idx_q  <= '0;
          if (trail_q) begin
            trail_q  <= 1'b0;
            nvalid_q <= '0;
          end else begin
            active_q <= 1'b0;
          end
        end else begin
          idx_q  <= idx_q + IDX_W'(1);
          sreg_q <= {1'b1, sreg_q[BYTE_W-1:1]};
        end
      end
    end
  end

  assign busy        = active_q;
  assign sclk        = sclk_q;
  assign sdata       = sreg_q[0];
  assign overrun     = ovr_q;
  assign bit_fire    = active_q && !phase_q;
  assign bit_val     = sreg_q[0];
  assign bit_is_data = ({1'b0, idx_q} < nvalid_q);
endmodule

// File: rtl/cfg_stream_serializer.sv
module cfg_stream_serializer
  import cfg_ser_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  logic [7:0]       wr_data,
  input  logic             fin_stb,
  input  logic [3:0]       fin_nbits,
  output logic             busy,
  output logic             sclk,
  output logic             sdata,
  output logic             hdr_seen,
  output logic             overrun,
  output logic [CNT_W-1:0] bit_count
);
  logic bit_fire, bit_val, bit_is_data, count_inc;

  cfg_shift_core u_core (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
    .fin_stb(fin_stb), .fin_nbits(fin_nbits), .busy(busy), .sclk(sclk),
    .sdata(sdata), .overrun(overrun), .bit_fire(bit_fire),
    .bit_val(bit_val), .bit_is_data(bit_is_data)
  );

  cfg_hdr_detect u_hdr (
    .clk(clk), .rst(rst), .bit_fire(bit_fire), .bit_val(bit_val),
    .seen(hdr_seen)
  );

  assign count_inc = bit_fire && bit_is_data;

  cfg_bit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(count_inc), .count(bit_count)
  );
endmodule

// File: rtl/cfg_stream_serializer_chk.sv
module cfg_stream_serializer_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_stb,
  input logic             fin_stb,
  input logic             busy,
  input logic             sclk,
  input logic             sdata,
  input logic             hdr_seen,
  input logic             overrun,
  input logic [CNT_W-1:0] bit_count,
  input logic             bit_fire,
  input logic             bit_is_data
);
  a_r1_idle_lines: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sclk && sdata));

  a_r2_data_steady_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(sdata));

  a_r2_change_while_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> !sclk);

  a_r3_hdr_sticky: assert property (@(posedge clk) disable iff (rst)
    hdr_seen |=> hdr_seen);

  a_r4_busy_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_stb || fin_stb));

  a_r5_count_on_data: assert property (@(posedge clk) disable iff (rst)
    (bit_fire && bit_is_data) |=> (bit_count == $past(bit_count) + CNT_W'(1)));

  a_r5_count_only_on_rise: assert property (@(posedge clk) disable iff (rst)
    (bit_count != $past(bit_count)) |-> $rose(sclk));

  a_r6_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (busy && (wr_stb || fin_stb)) |=> overrun);

  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  a_r9_clock_runs: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> (sclk != $past(sclk)));
endmodule

bind cfg_stream_serializer cfg_stream_serializer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .fin_stb(fin_stb), .busy(busy),
  .sclk(sclk), .sdata(sdata), .hdr_seen(hdr_seen), .overrun(overrun),
  .bit_count(bit_count), .bit_fire(bit_fire), .bit_is_data(bit_is_data)
);

// File: tb/test_cfg_stream_serializer.sv
module test_cfg_stream_serializer;
  localparam int CNT_W = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_stb = 1'b0, fin_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [3:0] fin_nbits = 4'd8;
  logic busy, sclk, sdata, hdr_seen, overrun;
  logic [CNT_W-1:0] bit_count;

  always #5 clk = ~clk;

  cfg_stream_serializer #(.CNT_W(CNT_W)) i_cfg_stream_serializer (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
    .fin_stb(fin_stb), .fin_nbits(fin_nbits), .busy(busy), .sclk(sclk),
    .sdata(sdata), .hdr_seen(hdr_seen), .overrun(overrun),
    .bit_count(bit_count)
  );

  int errs = 0, checks = 0;
  int exp_cnt = 0, pulses = 0;
  bit exp_q[$];
  logic [4:0] hist = 5'b0;
  bit hdr_exp = 1'b0;
  bit sclk_prev = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Scoreboard monitor: one expected bit per rising shift clock.
  always @(negedge clk) begin
    if (rst) sclk_prev = 1'b0;
    else begin
      if (sclk && !sclk_prev) begin
        pulses++;
        if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected pulse", 1, 0);
        else begin
          bit e;
          e = exp_q.pop_front();
          chk(sdata == e, "R2", "serial bit", sdata, e);
          hist = {hist[3:0], e};
          if (hist == 5'b10010) hdr_exp = 1'b1;
          chk(hdr_seen == hdr_exp, "R3", "header flag", hdr_seen, hdr_exp);
        end
      end
      sclk_prev = sclk;
    end
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] d);
    wait_idle();
    for (int i = 0; i < 8; i++) exp_q.push_back(d[i]);
    exp_cnt += 8;
    wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic fin_byte(input logic [7:0] d, input logic [3:0] n);
    int en;
    en = (n == 0 || n > 8) ? 8 : int'(n);
    wait_idle();
    for (int i = 0; i < 8; i++) exp_q.push_back(i < en ? d[i] : 1'b1);
    for (int i = 0; i < 8; i++) exp_q.push_back(1'b1);
    exp_cnt += en;
    wr_data = d; fin_nbits = n; fin_stb = 1'b1;
    @(negedge clk);
    fin_stb = 1'b0;
  endtask

  task automatic idle_checks(input string rq);
    chk(sclk == 1'b0, rq, "idle sclk", sclk, 0);
    chk(sdata == 1'b1, rq, "idle sdata", sdata, 1);
    chk(busy == 1'b0, rq, "idle busy", busy, 0);
  endtask

  task automatic settle();
    wait_idle();
    @(negedge clk);
    chk(exp_q.size() == 0, "R2", "bits left in scoreboard", exp_q.size(), 0);
    chk(int'(bit_count) == exp_cnt, "R5", "bit count", bit_count, exp_cnt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    idle_checks("R1");
    chk(hdr_seen == 1'b0, "R1", "reset hdr", hdr_seen, 0);
    chk(overrun == 1'b0, "R1", "reset overrun", overrun, 0);
    chk(bit_count == '0, "R1", "reset count", bit_count, 0);

    // R4 busy window, R2 eight pulses, R3 no header from 0x0F
    p0 = pulses;
    put_byte(8'h0F);
    chk(busy == 1'b1, "R4", "busy after strobe", busy, 1);
    repeat (15) @(negedge clk);
    chk(busy == 1'b1, "R4", "busy at cycle 15", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R4", "busy after 16 cycles", busy, 0);
    chk(pulses - p0 == 8, "R2", "pulses per byte", pulses - p0, 8);
    chk(hdr_seen == 1'b0, "R3", "no header yet", hdr_seen, 0);
    settle();

    // R6 overrun during 0xFF, then header via 0x04
    put_byte(8'hFF);
    wr_data = 8'h00; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    chk(overrun == 1'b1, "R6", "overrun set", overrun, 1);
    settle();
    chk(hdr_seen == 1'b0, "R3", "header after ones only", hdr_seen, 0);
    put_byte(8'h04);
    settle();
    chk(hdr_seen == 1'b1, "R3", "header after 0x04", hdr_seen, 1);
    chk(overrun == 1'b1, "R6", "overrun sticky", overrun, 1);

    // back-to-back plain bytes
    put_byte(8'hA5);
    put_byte(8'h3C);
    settle();

    // R7 R8 finish with 3 valid bits
    p0 = pulses;
    fin_byte(8'h05, 4'd3);
    repeat (31) @(negedge clk);
    chk(busy == 1'b1, "R8", "busy at cycle 31", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R8", "busy after 32 cycles", busy, 0);
    chk(pulses - p0 == 16, "R9", "pulses in finish", pulses - p0, 16);
    settle();
    idle_checks("R1");

    // R7 full last byte, and out-of-range bit count
    fin_byte(8'h00, 4'd8);
    settle();
    fin_byte(8'hC3, 4'd0);
    settle();
    fin_byte(8'h5A, 4'd1);
    settle();

    // R1 reset in the middle of a byte
    put_byte(8'hAA);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    exp_q.delete(); hist = 5'b0; hdr_exp = 1'b0; exp_cnt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_checks("R1");
    chk(hdr_seen == 1'b0, "R1", "hdr cleared", hdr_seen, 0);
    chk(overrun == 1'b0, "R1", "overrun cleared", overrun, 0);
    chk(bit_count == '0, "R1", "count cleared", bit_count, 0);
    put_byte(8'h81);
    settle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule